// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects the interrupt requests of a small communications CPU and turns them into a single call target. It has two external requests: a non-maskable pin that acts on its falling edge, and an active-low request pin that acts on its level. It also has four internal ones: a receiver event, transmit FIFO empty, line turnaround and timer expiry. A 2-bit select field picks which raw receiver event (FIFO full, data available or receiver active) drives the receiver slot. Each maskable source has its own enable bit, and a global enable gates all of them together.

The CPU raises `sample` once before each instruction. On that clock edge the controller looks at the pending requests and picks the one with the highest fixed priority. It then produces a one-cycle `take` pulse together with the chosen source code and a 16-bit vector address. The vector address joins an 8-bit base register with the source code, so the table entries sit four words apart. Taking any interrupt clears the global enable. Taking the non-maskable interrupt also clears its edge latch.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `take`, `vec_addr` and `src_code` are zero, the global enable is clear, and the enable field, select field and base register are zero. No maskable request is taken until software sets the global enable.
- R2: A high-to-low transition on `nmi_n` is stored in a latch. The stored request is taken at the next `sample`, whatever the global enable holds. Taking it clears the latch, so one edge yields exactly one take.
- R3: `ext_req_n` is level-sensitive and active low. It raises a request only while it is low at the edge where `sample` is high. A low pulse that ends before that edge is lost.
- R4: When several sources are active, priority from highest to lowest is: non-maskable, receiver, transmit empty, line turnaround, external request, timer. The choice depends only on which sources are active at the sampling edge.
- R5: Enable field bit 0 unmasks the receiver, bit 1 transmit empty, bit 2 line turnaround, bit 3 the external request and bit 4 the timer. A source whose bit is 0 is never taken.
- R6: The receiver select field picks the receiver event: 00 FIFO full, 01 data available, 11 receiver active. With 10 the receiver slot never requests.
- R7: Source codes are: non-maskable 111, receiver 001, transmit empty 010, line turnaround 011, external request 100, timer 101.
- R8: On a take, `vec_addr` holds the base register in bits 15:8, zero in bits 7:5, the source code in bits 4:2 and zero in bits 1:0. `vec_addr` and `src_code` hold their value until the next take.
- R9: The global enable gates every maskable source and has no effect on the non-maskable one. `gie_set` sets it, `gie_clr` clears it, and a take clears it at the same edge, with priority over `gie_set`.
- R10: A request is taken only at a clock edge where `sample` is high. That edge yields at most one take, and `take` is high during the following cycle only.
- R11: When `cfg_we` is high at a clock edge, the enable field, the select field and the base register load from `cfg_mask`, `cfg_rsel` and `cfg_base`. The new values govern decisions from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request, falling-edge active |
| ext_req_n | input | 1 | External request, low-level active |
| rx_full | input | 1 | Receive FIFO full or receive error |
| rx_avail | input | 1 | Receive data available or receive error |
| rx_active | input | 1 | Receiver saw a valid start sequence |
| tx_empty | input | 1 | Transmit FIFO empty |
| line_turn | input | 1 | Line turnaround (end of message) |
| tmr_zero | input | 1 | Timer reached zero |
| sample | input | 1 | Pre-instruction sampling strobe |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| cfg_we | input | 1 | Load enable field, select field and base |
| cfg_mask | input | 5 | New per-source enable bits |
| cfg_rsel | input | 2 | New receiver select value |
| cfg_base | input | 8 | New vector base register value |
| take | output | 1 | One-cycle interrupt-take pulse |
| vec_addr | output | 16 | Call vector of the last take |
| src_code | output | 3 | Source code of the last take |

## Verification
The bench builds the block with its default parameters: an 8-bit base, five maskable sources and a 2-bit select field. With these values every source code, every select encoding including the reserved one, and the full vector bit layout can be reached, and each vector value can be checked exactly. A behavioural model in the bench follows the edge latch, the global enable and the configuration, and it is compared with the outputs every cycle. Directed sequences drive priority collisions, masked sources, a lost external pulse and a non-maskable edge arriving with the global enable clear.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int CODE_W = 3;
  localparam int NSRC   = 6;  // index 0 = non-maskable (highest) .. 5 = timer
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t src_code_of(input int idx);
    case (idx)
      0:       src_code_of = 3'b111;
      1:       src_code_of = 3'b001;
      2:       src_code_of = 3'b010;
      3:       src_code_of = 3'b011;
      4:       src_code_of = 3'b100;
      5:       src_code_of = 3'b101;
      default: src_code_of = 3'b000;
    endcase
  endfunction

  function automatic logic rx_pick(input logic [1:0] sel, input logic full,
                                   input logic avail, input logic active);
    case (sel)
      2'b00:   rx_pick = full;
      2'b01:   rx_pick = avail;
      2'b11:   rx_pick = active;
      default: rx_pick = 1'b0;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] first_one(input logic [NSRC-1:0] req);
    logic found;
    first_one = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !found) begin
        first_one[i] = 1'b1;
        found = 1'b1;
      end
    end
  endfunction
endpackage

// File: rtl/ivc_nmi_latch.sv
module ivc_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic fell;

  assign fell = prev_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (fell)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ivc_req_gate.sv
module ivc_req_gate #(
  parameter int NMASK = 5
) (
  input  logic             gie,
  input  logic [NMASK-1:0] mask,
  input  logic [NMASK-1:0] raw,
  input  logic             nmi,
  output logic [NMASK:0]   req
);
  assign req[0] = nmi;
  for (genvar g = 0; g < NMASK; g++) begin : g_src
    assign req[g+1] = gie & mask[g] & raw[g];
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any,
  output code_t        code
);
  assign grant = first_one(req);
  assign any   = |req;

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = code | src_code_of(i);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int NMASK  = 5,
  parameter int RSEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nmi_n,
  input  logic                ext_req_n,
  input  logic                rx_full,
  input  logic                rx_avail,
  input  logic                rx_active,
  input  logic                tx_empty,
  input  logic                line_turn,
  input  logic                tmr_zero,
  input  logic                sample,
  input  logic                gie_set,
  input  logic                gie_clr,
  input  logic                cfg_we,
  input  logic [NMASK-1:0]    cfg_mask,
  input  logic [RSEL_W-1:0]   cfg_rsel,
  input  logic [BASE_W-1:0]   cfg_base,
  output logic                take,
  output logic [BASE_W+7:0]   vec_addr,
  output logic [CODE_W-1:0]   src_code
);
  localparam int ADDR_W = BASE_W + 8;
  localparam int NREQ   = NMASK + 1;

  function automatic logic [ADDR_W-1:0] make_vec(input logic [BASE_W-1:0] b,
                                                 input code_t c);
    make_vec = '0;
    make_vec[ADDR_W-1 -: BASE_W] = b;
    make_vec[2 +: CODE_W] = c;
  endfunction

  // Named internal events, visible to the bound checker
  logic               gie_q;
  logic [NMASK-1:0]   mask_q;
  logic [RSEL_W-1:0]  rsel_q;
  logic [BASE_W-1:0]  base_q;
  logic               nmi_pend;
  logic               rx_ev;
  logic               take_now;
  logic               nmi_taken;
  logic [NMASK-1:0]   raw;
  logic [NREQ-1:0]    req;
  logic [NREQ-1:0]    grant;
  logic               any_req;
  code_t              win_code;

  assign rx_ev = rx_pick(rsel_q[1:0], rx_full, rx_avail, rx_active);
  assign raw   = {tmr_zero, ~ext_req_n, line_turn, tx_empty, rx_ev};

  ivc_nmi_latch u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (nmi_n),
    .clr   (nmi_taken),
    .pend  (nmi_pend)
  );

  ivc_req_gate #(.NMASK(NMASK)) u_gate (
    .gie  (gie_q),
    .mask (mask_q),
    .raw  (raw),
    .nmi  (nmi_pend),
    .req  (req)
  );

  ivc_arbiter #(.N(NREQ)) u_arb (
    .req   (req),
    .grant (grant),
    .any   (any_req),
    .code  (win_code)
  );

  assign take_now  = sample & any_req;
  assign nmi_taken = take_now & grant[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      mask_q <= '0;
      rsel_q <= '0;
      base_q <= '0;
    end else begin
      if (take_now)     gie_q <= 1'b0;
      else if (gie_clr) gie_q <= 1'b0;
      else if (gie_set) gie_q <= 1'b1;
      if (cfg_we) begin
        mask_q <= cfg_mask;
        rsel_q <= cfg_rsel;
        base_q <= cfg_base;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec_addr <= '0;
      src_code <= '0;
    end else begin
      take <= take_now;
      if (take_now) begin
        vec_addr <= make_vec(base_q, win_code);
        src_code <= win_code;
      end
    end
  end
endmodule

module irq_vector_ctrl_chk #(
  parameter int BASE_W = 8,
  parameter int RSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample,
  input logic              take,
  input logic [BASE_W+7:0] vec_addr,
  input logic [2:0]        src_code,
  input logic              gie_q,
  input logic [RSEL_W-1:0] rsel_q,
  input logic              nmi_pend
);
  // R10
  take_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(sample));
  // R9
  gie_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !gie_q);
  // R9
  maskable_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_code != 3'b111) |-> $past(gie_q));
  // R8
  vec_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vec_addr[4:2] == src_code && vec_addr[7:5] == 3'b000 && vec_addr[1:0] == 2'b00));
  // R7
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (src_code != 3'b000 && src_code != 3'b110));
  // R6
  rsel_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_code == 3'b001) |-> ($past(rsel_q) != 2'b10));
  // R2
  nmi_from_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_code == 3'b111) |-> $past(nmi_pend));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.BASE_W(BASE_W), .RSEL_W(RSEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sample   (sample),
  .take     (take),
  .vec_addr (vec_addr),
  .src_code (src_code),
  .gie_q    (gie_q),
  .rsel_q   (rsel_q),
  .nmi_pend (nmi_pend)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1, ext_req_n = 1'b1;
  logic rx_full = 0, rx_avail = 0, rx_active = 0, tx_empty = 0, line_turn = 0, tmr_zero = 0;
  logic sample = 0, gie_set = 0, gie_clr = 0, cfg_we = 0;
  logic [4:0] cfg_mask = '0;
  logic [1:0] cfg_rsel = '0;
  logic [7:0] cfg_base = '0;
  logic take;
  logic [15:0] vec_addr;
  logic [2:0] src_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .ext_req_n(ext_req_n),
    .rx_full(rx_full), .rx_avail(rx_avail), .rx_active(rx_active),
    .tx_empty(tx_empty), .line_turn(line_turn), .tmr_zero(tmr_zero),
    .sample(sample), .gie_set(gie_set), .gie_clr(gie_clr), .cfg_we(cfg_we),
    .cfg_mask(cfg_mask), .cfg_rsel(cfg_rsel), .cfg_base(cfg_base),
    .take(take), .vec_addr(vec_addr), .src_code(src_code)
  );

  // Behavioural reference model
  int m_gie, m_rsel, m_base, m_prev, m_nlat, m_take, m_vec, m_code, m_win, m_rx;
  logic [4:0] m_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gie = 0; m_mask = 0; m_rsel = 0; m_base = 0; m_prev = 1; m_nlat = 0;
      m_take = 0; m_vec = 0; m_code = 0;
    end else begin
      if (m_rsel == 0)      m_rx = rx_full;
      else if (m_rsel == 1) m_rx = rx_avail;
      else if (m_rsel == 3) m_rx = rx_active;
      else                  m_rx = 0;
      m_win = 0;
      if (sample) begin
        if (m_nlat != 0) m_win = 7;
        else if (m_gie != 0) begin
          if (m_mask[0] && m_rx != 0)        m_win = 1;
          else if (m_mask[1] && tx_empty)    m_win = 2;
          else if (m_mask[2] && line_turn)   m_win = 3;
          else if (m_mask[3] && !ext_req_n)  m_win = 4;
          else if (m_mask[4] && tmr_zero)    m_win = 5;
        end
      end
      m_take = (m_win != 0) ? 1 : 0;
      if (m_take != 0) begin
        m_code = m_win;
        m_vec  = m_base * 256 + m_win * 4;
      end
      if (m_win == 7) m_nlat = 0;
      if (m_prev == 1 && nmi_n == 1'b0) m_nlat = 1;
      m_prev = nmi_n;
      if (m_take != 0)  m_gie = 0;
      else if (gie_clr) m_gie = 0;
      else if (gie_set) m_gie = 1;
      if (cfg_we) begin
        m_mask = cfg_mask; m_rsel = cfg_rsel; m_base = cfg_base;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(take == m_take[0], "R10 model take", take, m_take);
      check(src_code == m_code[2:0], "R4 R7 model code", src_code, m_code);
      check(vec_addr == m_vec[15:0], "R8 model vector", vec_addr, m_vec);
    end
  end

  task automatic strobe_chk(input bit et, input int ec, input int ev, input string tag);
    @(negedge clk) sample = 1'b1;
    @(negedge clk) sample = 1'b0;
    check(take == et, {tag, " take"}, take, et);
    if (et) begin
      check(src_code == ec[2:0], {tag, " code"}, src_code, ec);
      check(vec_addr == ev[15:0], {tag, " vector"}, vec_addr, ev);
    end
  endtask

  task automatic pulse_gie();
    @(negedge clk) gie_set = 1'b1;
    @(negedge clk) gie_set = 1'b0;
  endtask

  task automatic write_cfg(input logic [4:0] m, input logic [1:0] r, input logic [7:0] b);
    @(negedge clk) begin cfg_we = 1'b1; cfg_mask = m; cfg_rsel = r; cfg_base = b; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic clear_raw();
    @(negedge clk) begin
      rx_full = 0; rx_avail = 0; rx_active = 0; tx_empty = 0;
      line_turn = 0; tmr_zero = 0; ext_req_n = 1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    check(take == 1'b0, "R1 reset take", take, 0);
    check(vec_addr == 16'h0, "R1 reset vector", vec_addr, 0);
    check(src_code == 3'b0, "R1 reset code", src_code, 0);
    // R1: maskable sources blocked with global enable clear
    @(negedge clk) begin rx_full = 1; tx_empty = 1; ext_req_n = 0; tmr_zero = 1; end
    strobe_chk(0, 0, 0, "R1 no take after reset");
    write_cfg(5'h1F, 2'b00, 8'h00);
    strobe_chk(0, 0, 0, "R9 enable clear blocks");
    clear_raw();

    // R2: falling edge on the non-maskable pin, global enable clear
    @(negedge clk) nmi_n = 0;
    @(negedge clk) nmi_n = 1;
    repeat (2) @(negedge clk);
    check(take == 1'b0, "R10 no take without strobe", take, 0);
    strobe_chk(1, 7, 16'h001C, "R2 R9 nmi without enable");
    strobe_chk(0, 0, 0, "R2 latch cleared after take");

    // R4 R7 R8 R11: receiver beats transmit empty, base loaded
    write_cfg(5'h1F, 2'b00, 8'hA5);
    pulse_gie();
    @(negedge clk) begin rx_full = 1; tx_empty = 1; tmr_zero = 1; end
    strobe_chk(1, 1, 16'hA504, "R4 R11 receiver first");
    strobe_chk(0, 0, 0, "R9 enable cleared by take");
    pulse_gie();
    @(negedge clk) rx_full = 0;
    strobe_chk(1, 2, 16'hA508, "R4 transmit empty next");
    pulse_gie();
    @(negedge clk) begin tx_empty = 0; line_turn = 1; ext_req_n = 0; end
    strobe_chk(1, 3, 16'hA50C, "R4 R7 line turnaround");
    // R4: non-maskable beats everything while enabled
    pulse_gie();
    @(negedge clk) begin nmi_n = 0; rx_full = 1; end
    @(negedge clk) nmi_n = 1;
    strobe_chk(1, 7, 16'hA51C, "R4 nmi highest");
    clear_raw();

    // R9: gie_clr removes the enable
    pulse_gie();
    @(negedge clk) gie_clr = 1;
    @(negedge clk) begin gie_clr = 0; tmr_zero = 1; end
    strobe_chk(0, 0, 0, "R9 gie_clr blocks");

    // R5: only the timer unmasked
    write_cfg(5'b10000, 2'b00, 8'hA5);
    pulse_gie();
    @(negedge clk) begin rx_full = 1; tx_empty = 1; line_turn = 1; ext_req_n = 0; end
    strobe_chk(1, 5, 16'hA514, "R5 only timer unmasked");
    pulse_gie();
    @(negedge clk) tmr_zero = 0;
    strobe_chk(0, 0, 0, "R5 masked sources ignored");
    clear_raw();

    // R3: short external pulse is lost, held level is taken
    write_cfg(5'h1F, 2'b00, 8'hA5);
    pulse_gie();
    @(negedge clk) ext_req_n = 0;
    @(negedge clk) ext_req_n = 1;
    strobe_chk(0, 0, 0, "R3 pulse before strobe lost");
    @(negedge clk) ext_req_n = 0;
    strobe_chk(1, 4, 16'hA510, "R3 low level taken");
    clear_raw();

    // R6: receiver select encodings
    write_cfg(5'b00001, 2'b01, 8'h3C);
    pulse_gie();
    @(negedge clk) rx_full = 1;
    strobe_chk(0, 0, 0, "R6 full ignored when avail selected");
    @(negedge clk) rx_avail = 1;
    strobe_chk(1, 1, 16'h3C04, "R6 data available");
    write_cfg(5'b00001, 2'b10, 8'h3C);
    pulse_gie();
    @(negedge clk) rx_active = 1;
    strobe_chk(0, 0, 0, "R6 reserved select");
    write_cfg(5'b00001, 2'b11, 8'h3C);
    strobe_chk(1, 1, 16'h3C04, "R6 receiver active");
    clear_raw();

    // R10: strobe held two cycles gives one take per strobe edge
    write_cfg(5'h1F, 2'b00, 8'h81);
    pulse_gie();
    @(negedge clk) begin tmr_zero = 1; sample = 1; end
    @(negedge clk);
    check(take == 1'b1, "R10 first strobe take", take, 1);
    check(vec_addr == 16'h8114, "R8 R10 vector", vec_addr, 16'h8114);
    @(negedge clk) sample = 0;
    check(take == 1'b0, "R10 single pulse", take, 0);
    check(vec_addr == 16'h8114, "R8 vector held", vec_addr, 16'h8114);
    clear_raw();
    repeat (3) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule